// File: doc/BRIEF.md
# Delayed Transaction Target Tracker

This block sits on the target side of a shared parallel bus. It turns a slow read, or a write that cannot be posted, into a delayed transaction. Each access attempt arrives as a one-cycle strobe. The strobe carries a write flag, a command code, an address, byte enables and write data. The tracker answers every attempt on the next cycle with exactly one of two outcomes:

- **retry**: the attempt must be issued again later.
- **done**: the attempt completes and, for a read, carries data.

The first attempt that finds the tracker idle is recorded in its single slot and answered with retry. The recorded access is then run on a back-end port. That port holds a request line high until it receives a one-cycle acknowledge. A later attempt whose fields all equal the recorded ones receives the buffered result. The match does not depend on which initiator sends the attempt. Any other attempt made while the slot is busy is answered with retry and is not recorded.

A discard timer drops an abandoned slot, so a lost initiator cannot hold the bus. The timer runs from the recording edge for `TIMEOUT` cycles (32768 by default). An active-low reset also clears the slot.

The controller has four states:

- **IDLE**: the slot is empty.
- **PENDING**: the back-end access is in progress.
- **COMPLETE**: the result is buffered.
- **DELIVER**: the result was handed over in this cycle.

Its transitions:

- IDLE→PENDING on *record*.
- PENDING→COMPLETE on *back-end acknowledge*.
- COMPLETE→DELIVER on *matching attempt*.
- DELIVER→IDLE on *release*.
- PENDING→IDLE and COMPLETE→IDLE on *expiry*.
- Any state→IDLE on reset.

Top module: `dly_txn_tracker`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_retry`, `rsp_done` and `be_req` are all 0.
- R2: An attempt that finds the tracker in IDLE is answered with retry one cycle later. From that same edge, `be_req` is 1 and the back-end fields equal the recorded write flag, command, address, byte enables and write data.
- R3: The back-end fields stay stable while `be_req` is high. `be_req` stays high until the cycle after `be_ack` is sampled, unless the slot expires first.
- R4: While PENDING, every attempt is answered with retry, whether or not it matches.
- R5: In COMPLETE, a matching attempt is answered with done one cycle later. A read carries the data returned with `be_ack`; a write carries all-zero data.
- R6: An attempt matches only if its write flag, command, address and byte enables all equal the recorded ones and, for a recorded write, every data byte also equals the recorded data. Write data is ignored when the recorded access is a read. A non-matching attempt in COMPLETE is answered with retry, and the buffered result is kept.
- R7: An attempt answered with retry while the slot is busy is never recorded. No back-end request arises from it.
- R8: Done is asserted for exactly one cycle (DELIVER). An attempt in that cycle is answered with retry and is not recorded. The slot is IDLE on the next edge.
- R9: Take the edge that records a slot as edge 0. With no delivery, the slot is discarded at edge `TIMEOUT`, and `be_req` falls there if still high. A matching attempt at edge `TIMEOUT-1` is still served. An attempt at edge `TIMEOUT` receives retry and is not recorded.
- R10: Every attempt gets a response exactly one cycle later, well inside a 16-cycle bound. `rsp_valid` is 1 only in that cycle, and exactly one of `rsp_retry` and `rsp_done` is 1 with it.
- R11: A reset asserted while a slot is held discards the slot. The next attempt is recorded afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also clears the slot |
| req_valid | input | 1 | One-cycle strobe for an access attempt |
| req_write | input | 1 | Attempt is a write (1) or a read (0) |
| req_cmd | input | CMD_W | Command code of the attempt |
| req_addr | input | ADDR_W | Address of the attempt |
| req_be | input | DATA_W/8 | Byte enables of the attempt |
| req_wdata | input | DATA_W | Write data of the attempt |
| rsp_valid | output | 1 | Response to the attempt of the previous cycle |
| rsp_retry | output | 1 | Attempt must be repeated |
| rsp_done | output | 1 | Attempt completed with the buffered result |
| rsp_rdata | output | DATA_W | Read data carried with done |
| be_req | output | 1 | Back-end access request, held until acknowledged |
| be_write | output | 1 | Back-end access is a write |
| be_cmd | output | CMD_W | Recorded command code |
| be_addr | output | ADDR_W | Recorded address |
| be_be | output | DATA_W/8 | Recorded byte enables |
| be_wdata | output | DATA_W | Recorded write data |
| be_ack | input | 1 | One-cycle back-end completion |
| be_rdata | input | DATA_W | Back-end read data, valid with be_ack |

## Verification
The bench builds the tracker with an 8-bit address, 16-bit data (two byte lanes), a 4-bit command and `TIMEOUT` = 64. The short timeout brings the discard edges `TIMEOUT-1` and `TIMEOUT` within a few dozen cycles, in both PENDING and COMPLETE. The narrow fields allow a full sweep over 16 addresses, every non-zero byte-enable pattern and both directions. In each case the back-end latency is derived from the address, and the expected read data is computed from the address.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

    // Controller states of the single delayed-transaction slot
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PENDING  = 2'd1,
        ST_COMPLETE = 2'd2,
        ST_DELIVER  = 2'd3
    } dtt_state_e;

    // Outcome sent back for an attempt
    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_RETRY = 2'd1,
        RSP_DONE  = 2'd2
    } dtt_rsp_e;

endpackage

// File: rtl/dtt_txn_match.sv
module dtt_txn_match #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CMD_W  = 4,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              rec_write,
    input  logic [CMD_W-1:0]  rec_cmd,
    input  logic [ADDR_W-1:0] rec_addr,
    input  logic [BE_W-1:0]   rec_be,
    input  logic [DATA_W-1:0] rec_wdata,
    input  logic              in_write,
    input  logic [CMD_W-1:0]  in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              hit
);

    logic [BE_W-1:0] lane_eq;
    logic            hdr_eq;

    // Per-lane data comparison
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_eq[g] = (rec_wdata[g*8 +: 8] == in_wdata[g*8 +: 8]);
    end

    assign hdr_eq = (rec_write == in_write) && (rec_cmd == in_cmd) &&
                    (rec_addr == in_addr) && (rec_be == in_be);

    // Data only takes part when the recorded access is a write
    assign hit = hdr_eq && (!rec_write || (&lane_eq));

endmodule

// File: rtl/dtt_discard_timer.sv
module dtt_discard_timer #(
    parameter int LIMIT = 32768,
    localparam int CW   = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fires on the LIMIT-th edge after the clearing edge
    assign expired = run && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/dtt_txn_store.sv
module dtt_txn_store #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CMD_W  = 4,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_write,
    input  logic [CMD_W-1:0]  in_cmd,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BE_W-1:0]   in_be,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] cap_data,
    output logic              rec_write,
    output logic [CMD_W-1:0]  rec_cmd,
    output logic [ADDR_W-1:0] rec_addr,
    output logic [BE_W-1:0]   rec_be,
    output logic [DATA_W-1:0] rec_wdata,
    output logic [DATA_W-1:0] rec_rdata
);

    // Recorded attempt fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_write <= 1'b0;
            rec_cmd   <= '0;
            rec_addr  <= '0;
            rec_be    <= '0;
            rec_wdata <= '0;
        end else if (load) begin
            rec_write <= in_write;
            rec_cmd   <= in_cmd;
            rec_addr  <= in_addr;
            rec_be    <= in_be;
            rec_wdata <= in_wdata;
        end
    end

    // Buffered back-end result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_rdata <= '0;
        end else if (capture) begin
            rec_rdata <= cap_data;
        end
    end

endmodule

// File: rtl/dly_txn_tracker.sv
module dly_txn_tracker
    import dtt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int CMD_W   = 4,
    parameter int TIMEOUT = 32768,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_retry,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              be_req,
    output logic              be_write,
    output logic [CMD_W-1:0]  be_cmd,
    output logic [ADDR_W-1:0] be_addr,
    output logic [BE_W-1:0]   be_be,
    output logic [DATA_W-1:0] be_wdata,
    input  logic              be_ack,
    input  logic [DATA_W-1:0] be_rdata
);

    dtt_state_e state_q, state_d;
    dtt_rsp_e   rsp_kind;
    logic       load_slot;
    logic       capture_res;
    logic       timer_run;
    logic       expired;
    logic       hit;
    logic       rec_write;
    logic [CMD_W-1:0]  rec_cmd;
    logic [ADDR_W-1:0] rec_addr;
    logic [BE_W-1:0]   rec_be;
    logic [DATA_W-1:0] rec_wdata;
    logic [DATA_W-1:0] rec_rdata;

    dtt_txn_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_slot),
        .in_write (req_write),
        .in_cmd   (req_cmd),
        .in_addr  (req_addr),
        .in_be    (req_be),
        .in_wdata (req_wdata),
        .capture  (capture_res),
        .cap_data (be_rdata),
        .rec_write(rec_write),
        .rec_cmd  (rec_cmd),
        .rec_addr (rec_addr),
        .rec_be   (rec_be),
        .rec_wdata(rec_wdata),
        .rec_rdata(rec_rdata)
    );

    dtt_txn_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) i_match (
        .rec_write(rec_write),
        .rec_cmd  (rec_cmd),
        .rec_addr (rec_addr),
        .rec_be   (rec_be),
        .rec_wdata(rec_wdata),
        .in_write (req_write),
        .in_cmd   (req_cmd),
        .in_addr  (req_addr),
        .in_be    (req_be),
        .in_wdata (req_wdata),
        .hit      (hit)
    );

    dtt_discard_timer #(.LIMIT(TIMEOUT)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load_slot),
        .run    (timer_run),
        .expired(expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_PENDING;             // record
            end
            ST_PENDING: begin
                if (expired)     state_d = ST_IDLE;              // expiry
                else if (be_ack) state_d = ST_COMPLETE;          // back-end acknowledge
            end
            ST_COMPLETE: begin
                if (expired)               state_d = ST_IDLE;    // expiry
                else if (req_valid && hit) state_d = ST_DELIVER; // matching attempt
            end
            ST_DELIVER: begin
                state_d = ST_IDLE;                               // release
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Control outputs
    always_comb begin
        rsp_kind    = RSP_NONE;
        load_slot   = 1'b0;
        capture_res = 1'b0;
        timer_run   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    load_slot = 1'b1;
                    rsp_kind  = RSP_RETRY;
                end
            end
            ST_PENDING: begin
                timer_run   = 1'b1;
                capture_res = be_ack && !expired;
                if (req_valid) rsp_kind = RSP_RETRY;
            end
            ST_COMPLETE: begin
                timer_run = 1'b1;
                if (req_valid) begin
                    rsp_kind = (hit && !expired) ? RSP_DONE : RSP_RETRY;
                end
            end
            ST_DELIVER: begin
                if (req_valid) rsp_kind = RSP_RETRY;
            end
            default: rsp_kind = RSP_NONE;
        endcase
    end

    // Response register: answer appears the cycle after the attempt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_retry <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (rsp_kind != RSP_NONE);
            rsp_retry <= (rsp_kind == RSP_RETRY);
            rsp_done  <= (rsp_kind == RSP_DONE);
            rsp_rdata <= ((rsp_kind == RSP_DONE) && !rec_write) ? rec_rdata : '0;
        end
    end

    assign be_req   = (state_q == ST_PENDING);
    assign be_write = rec_write;
    assign be_cmd   = rec_cmd;
    assign be_addr  = rec_addr;
    assign be_be    = rec_be;
    assign be_wdata = rec_wdata;

endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic              rsp_retry,
    input logic              rsp_done,
    input logic              be_req,
    input logic [CMD_W-1:0]  be_cmd,
    input logic [ADDR_W-1:0] be_addr
);

    // R10
    answer_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid && (rsp_retry != rsp_done));

    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R3
    be_fields_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && $past(be_req)) |-> ($stable(be_addr) && $stable(be_cmd)));

    // R8
    single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R2
    record_on_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(be_req) |-> (rsp_valid && rsp_retry));

endmodule

bind dly_txn_tracker dtt_checker #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .rsp_valid(rsp_valid),
    .rsp_retry(rsp_retry),
    .rsp_done (rsp_done),
    .be_req   (be_req),
    .be_cmd   (be_cmd),
    .be_addr  (be_addr)
);

// File: tb/test_dly_txn_tracker.sv
module test_dly_txn_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 16;
    localparam int CMD_W   = 4;
    localparam int TIMEOUT = 64;
    localparam int BE_W    = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [CMD_W-1:0]  req_cmd = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [BE_W-1:0]   req_be = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid, rsp_retry, rsp_done;
    logic [DATA_W-1:0] rsp_rdata;
    logic              be_req, be_write;
    logic [CMD_W-1:0]  be_cmd;
    logic [ADDR_W-1:0] be_addr;
    logic [BE_W-1:0]   be_be;
    logic [DATA_W-1:0] be_wdata;
    logic              be_ack = 1'b0;
    logic [DATA_W-1:0] be_rdata = '0;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  be_en = 1'b1;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dly_txn_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W), .TIMEOUT(TIMEOUT))
    i_dly_txn_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .be_req(be_req), .be_write(be_write), .be_cmd(be_cmd),
        .be_addr(be_addr), .be_be(be_be), .be_wdata(be_wdata), .be_ack(be_ack),
        .be_rdata(be_rdata)
    );

    function automatic logic [DATA_W-1:0] model_data(logic [ADDR_W-1:0] a, logic [BE_W-1:0] b);
        return {a ^ 8'hA5, a + 8'h3C} ^ {14'd0, b};
    endfunction

    // Back-end model: latency taken from the address
    int wait_cnt = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (be_ack) begin
                be_ack = 1'b0;
            end else if (be_req && be_en) begin
                if (wait_cnt >= int'(be_addr % 4)) begin
                    be_ack   = 1'b1;
                    be_rdata = model_data(be_addr, be_be);
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // One attempt: drive at a negedge, sample at the next negedge
    task automatic attempt(bit w, logic [CMD_W-1:0] c, logic [ADDR_W-1:0] a,
                           logic [BE_W-1:0] b, logic [DATA_W-1:0] d);
        req_valid = 1'b1; req_write = w; req_cmd = c; req_addr = a;
        req_be = b; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        be_en = 1'b1;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic expect_retry(string req);
        check(rsp_valid && rsp_retry && !rsp_done, req,
              {29'd0, rsp_valid, rsp_retry, rsp_done}, 32'h6);
    endtask

    task automatic expect_done(string req, logic [DATA_W-1:0] exp);
        check(rsp_valid && rsp_done && !rsp_retry && rsp_rdata == exp, req,
              {13'd0, rsp_valid, rsp_retry, rsp_done, rsp_rdata},
              {13'd0, 3'b101, exp});
    endtask

    // Record, wait out PENDING, probe, deliver
    task automatic run_flow(bit w, logic [CMD_W-1:0] c, logic [ADDR_W-1:0] a,
                            logic [BE_W-1:0] b, logic [DATA_W-1:0] d);
        int guard;
        attempt(w, c, a, b, d);
        expect_retry("R2 first attempt");
        check(be_req && be_write == w && be_cmd == c && be_addr == a &&
              be_be == b && be_wdata == d, "R2 back-end fields",
              {7'd0, be_req, be_write, be_cmd, be_be, be_addr, 9'd0},
              {7'd0, 1'b1, w, c, b, a, 9'd0});
        guard = 0;
        while (be_req && guard < 20) begin
            attempt(w, c, (guard % 2 == 1) ? a ^ 8'h01 : a, b, d);
            expect_retry("R4 attempt while pending");
            guard++;
        end
        check(!be_req, "R3 request drops after ack", {31'd0, be_req}, 32'd0);
        attempt(w, c ^ 4'h1, a, b, d);
        expect_retry("R6 non-matching in complete");
        attempt(w, c, a, b, d);
        expect_done("R5 matching delivery", w ? '0 : model_data(a, b));
        idle(1);
        check(!be_req && !rsp_valid, "R7 probes not recorded",
              {30'd0, be_req, rsp_valid}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(2);
        // R1 during reset
        check(!rsp_valid && !rsp_retry && !rsp_done && !be_req, "R1 reset state",
              {28'd0, rsp_valid, rsp_retry, rsp_done, be_req}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        check(!rsp_valid && !be_req, "R1 after reset",
              {30'd0, rsp_valid, be_req}, 32'd0);

        // Sweep: addresses, byte enables, direction
        for (int a = 0; a < 16; a++) begin
            for (int b = 1; b < 4; b++) begin
                for (int w = 0; w < 2; w++) begin
                    run_flow(w[0], 4'(a % 16) ^ 4'h6, 8'(a * 7), 2'(b), 16'(a * 257 + b));
                end
            end
        end

        // R6: field-by-field mismatch against a recorded read, then a recorded write
        do_reset();
        attempt(1'b0, 4'h6, 8'h20, 2'b11, 16'h1111);
        idle(4);
        attempt(1'b1, 4'h6, 8'h20, 2'b11, 16'h1111);
        expect_retry("R6 write flag differs");
        attempt(1'b0, 4'h7, 8'h20, 2'b11, 16'h1111);
        expect_retry("R6 command differs");
        attempt(1'b0, 4'h6, 8'h21, 2'b11, 16'h1111);
        expect_retry("R6 address differs");
        attempt(1'b0, 4'h6, 8'h20, 2'b01, 16'h1111);
        expect_retry("R6 byte enables differ");
        attempt(1'b0, 4'h6, 8'h20, 2'b11, 16'hBEEF);
        expect_done("R6 read ignores write data", model_data(8'h20, 2'b11));
        // R8: attempt in the deliver cycle is retried and not recorded
        attempt(1'b0, 4'h6, 8'h20, 2'b11, 16'h1111);
        expect_retry("R8 attempt during deliver");
        check(!be_req, "R8 deliver attempt not recorded", {31'd0, be_req}, 32'd0);
        attempt(1'b0, 4'h6, 8'h20, 2'b11, 16'h1111);
        expect_retry("R8 slot free again");
        check(be_req, "R8 new record after release", {31'd0, be_req}, 32'd1);

        do_reset();
        attempt(1'b1, 4'h3, 8'h24, 2'b10, 16'hA0A0);
        idle(4);
        attempt(1'b1, 4'h3, 8'h24, 2'b10, 16'hA0A1);
        expect_retry("R6 write data low byte differs");
        attempt(1'b1, 4'h3, 8'h24, 2'b10, 16'hB0A0);
        expect_retry("R6 write data high byte differs");
        attempt(1'b1, 4'h3, 8'h24, 2'b10, 16'hA0A0);
        expect_done("R6 write match kept after mismatches", 16'h0000);

        // R9: expiry while pending (back-end stalled)
        do_reset();
        be_en = 1'b0;
        attempt(1'b0, 4'h2, 8'h40, 2'b01, 16'h0);
        idle(TIMEOUT - 1);
        check(be_req, "R9 still pending at TIMEOUT-1", {31'd0, be_req}, 32'd1);
        idle(1);
        check(!be_req, "R9 discarded at TIMEOUT", {31'd0, be_req}, 32'd0);
        be_en = 1'b1;
        attempt(1'b0, 4'h2, 8'h40, 2'b01, 16'h0);
        expect_retry("R9 fresh record after expiry");
        check(be_req, "R9 fresh back-end request", {31'd0, be_req}, 32'd1);

        // R9: delivery at the last edge, then expiry in complete
        do_reset();
        attempt(1'b0, 4'h2, 8'h41, 2'b11, 16'h0);
        idle(TIMEOUT - 2);
        attempt(1'b0, 4'h2, 8'h41, 2'b11, 16'h0);
        expect_done("R9 served at TIMEOUT-1", model_data(8'h41, 2'b11));
        do_reset();
        attempt(1'b0, 4'h2, 8'h42, 2'b11, 16'h0);
        idle(TIMEOUT - 1);
        attempt(1'b0, 4'h2, 8'h42, 2'b11, 16'h0);
        expect_retry("R9 retried at TIMEOUT");
        check(!be_req, "R9 expiry attempt not recorded", {31'd0, be_req}, 32'd0);
        attempt(1'b0, 4'h2, 8'h42, 2'b11, 16'h0);
        check(be_req && rsp_retry, "R9 recorded afresh",
              {30'd0, be_req, rsp_retry}, 32'd3);

        // R11: reset discards a held slot
        do_reset();
        be_en = 1'b0;
        attempt(1'b1, 4'h9, 8'h55, 2'b01, 16'h00FF);
        rst_n = 1'b0;
        idle(1);
        check(!be_req && !rsp_valid, "R11 reset clears slot",
              {30'd0, be_req, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        be_en = 1'b1;
        idle(1);
        attempt(1'b0, 4'h1, 8'h56, 2'b10, 16'h0);
        check(be_req && rsp_retry && be_addr == 8'h56, "R11 new record after reset",
              {22'd0, be_req, rsp_retry, be_addr}, {22'd0, 2'b11, 8'h56});
        // R10: no response without an attempt
        idle(1);
        check(!rsp_valid, "R10 no response without attempt", {31'd0, rsp_valid}, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule